// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block holds the coherence state of every line of one private cache in a small multiprocessor. The caches share a snooping bus and keep one another up to date with a write-update protocol. Each line is invalid, exclusive, shared or dirty. The processor side presents reads, writes and evictions. The controller answers each one in the same cycle. It either completes it silently or puts one bus transaction on the bus: a fill read, an update broadcast or a writeback. In the same cycle it samples the wired-OR sharing signal, which the other caches drive, to choose the new state.

On the snoop side, the controller watches transactions from other caches. It raises its own sharing signal when it holds the addressed line. It supplies and writes back dirty data when another cache reads that data. It refreshes shared copies when another cache broadcasts an update. When a snoop and a processor request arrive together, the snoop wins and the processor request is held off. Three saturating counters record the fill reads, update broadcasts and writebacks this cache has caused.

The tag and data arrays sit outside this block. They address the controller by line index and use the lookup port to read a line's state.

Top module: `wu_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid (state code 0) and all three counters read 0. State codes are invalid=0, exclusive=1, shared=2, dirty=3. Processor op codes are read=0, write=1, evict=2. Bus and snoop op codes are none=0, read=1, update=2, writeback=3.
- R2: A processor read to an invalid line issues a bus read in the same cycle and is acknowledged. The line becomes shared if `shared_in` is high in that cycle and exclusive otherwise.
- R3: A processor read to a valid line issues no bus transaction and leaves the state unchanged.
- R4: A processor write to an exclusive line moves it to dirty with no bus transaction. A write to a dirty line stays dirty with no bus transaction.
- R5: A processor write to a shared line issues exactly one bus update in that cycle. The line stays shared if `shared_in` is high and returns to exclusive if it is low.
- R6: A processor write to an invalid line issues a bus read. With `shared_in` low the line becomes dirty and the request is acknowledged. With `shared_in` high the line becomes shared and `proc_ack` stays low, so the retried write then hits a shared line.
- R7: Evicting a dirty line issues a bus writeback and the line becomes invalid. Evicting an exclusive or shared line is silent and the line becomes invalid.
- R8: A snooped read to a line held exclusive or dirty raises `shared_out` and moves the line to shared. If the line was dirty, `supply_data` is also raised.
- R9: A snooped update to a valid line raises `shared_out` and `refresh` and leaves the line shared. A snoop of any kind to an invalid line, and a snooped writeback, raise none of `shared_out`, `supply_data` or `refresh` and change no state.
- R10: While `snp_valid` is high, a processor request is not acknowledged, issues no bus transaction and changes no state.
- R11: `cnt_rd` counts issued bus reads and `cnt_upd` counts issued updates. `cnt_wb` counts issued writebacks plus data supplies. Each counter stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_valid | input | 1 | Processor request present |
| proc_op | input | 2 | Processor op: read, write, evict |
| proc_idx | input | IDX_W | Line index of the processor request |
| proc_ack | output | 1 | Processor request completed this cycle |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_op | input | 2 | Snooped op code |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| shared_in | input | 1 | Wired-OR sharing signal driven by the other caches |
| shared_out | output | 1 | This cache's contribution to the sharing signal |
| supply_data | output | 1 | This cache supplies and writes back the snooped dirty line |
| refresh | output | 1 | Snooped update data is written into the local copy |
| bus_req_valid | output | 1 | This cache issues a bus transaction |
| bus_req_op | output | 2 | Op code of the issued transaction |
| bus_req_idx | output | IDX_W | Line index of the issued transaction |
| lookup_idx | input | IDX_W | Line index for the state lookup |
| lookup_state | output | 2 | Current state of the looked-up line |
| cnt_rd | output | CNT_W | Saturating count of bus reads |
| cnt_upd | output | CNT_W | Saturating count of update broadcasts |
| cnt_wb | output | CNT_W | Saturating count of writebacks and supplies |

## Verification
The bench builds the controller with four lines and 4-bit counters. With four lines, one stimulus table can keep several lines in different states at once, which exposes index cross-talk. With 4-bit counters, the read counter can be driven past its all-ones value in a few dozen cycles, so the saturation limit of R11 is checked directly. A reset applied in mid-run confirms that state and counters both return to their initial values.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [1:0] {
    LS_INV  = 2'd0,
    LS_EXCL = 2'd1,
    LS_SHR  = 2'd2,
    LS_DIRT = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    PO_READ  = 2'd0,
    PO_WRITE = 2'd1,
    PO_EVICT = 2'd2,
    PO_RSVD  = 2'd3
  } proc_op_e;

  typedef enum logic [1:0] {
    BO_NONE = 2'd0,
    BO_READ = 2'd1,
    BO_UPD  = 2'd2,
    BO_WB   = 2'd3
  } bus_op_e;

  // State a line takes after a fill read, given the sharing wire
  function automatic line_state_e fill_state(input logic others_share);
    return others_share ? LS_SHR : LS_EXCL;
  endfunction

  // State a shared line takes after its own update broadcast
  function automatic line_state_e post_update_state(input logic others_share);
    return others_share ? LS_SHR : LS_EXCL;
  endfunction
endpackage

// File: rtl/wu_proc_fsm.sv
module wu_proc_fsm
  import wu_pkg::*;
(
  input  logic        proc_valid,
  input  logic [1:0]  proc_op,
  input  line_state_e cur,
  input  logic        shared_in,
  input  logic        blocked,
  output logic        ack,
  output logic        bus_valid,
  output bus_op_e     bus_op,
  output logic        we,
  output line_state_e nxt
);
  logic active;
  assign active = proc_valid && !blocked;

  always_comb begin
    ack       = 1'b0;
    bus_valid = 1'b0;
    bus_op    = BO_NONE;
    we        = 1'b0;
    nxt       = cur;
    if (active) begin
      ack = 1'b1;
      unique case (proc_op)
        PO_READ: begin
          if (cur == LS_INV) begin
            bus_valid = 1'b1;
            bus_op    = BO_READ;
            we        = 1'b1;
            nxt       = fill_state(shared_in);
          end
        end
        PO_WRITE: begin
          unique case (cur)
            LS_INV: begin
              bus_valid = 1'b1;
              bus_op    = BO_READ;
              we        = 1'b1;
              nxt       = shared_in ? LS_SHR : LS_DIRT;
              ack       = !shared_in;
            end
            LS_EXCL: begin
              we  = 1'b1;
              nxt = LS_DIRT;
            end
            LS_SHR: begin
              bus_valid = 1'b1;
              bus_op    = BO_UPD;
              we        = 1'b1;
              nxt       = post_update_state(shared_in);
            end
            default: ;
          endcase
        end
        PO_EVICT: begin
          we  = 1'b1;
          nxt = LS_INV;
          if (cur == LS_DIRT) begin
            bus_valid = 1'b1;
            bus_op    = BO_WB;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wu_snoop_resp.sv
module wu_snoop_resp
  import wu_pkg::*;
(
  input  logic        snp_valid,
  input  logic [1:0]  snp_op,
  input  line_state_e cur,
  output logic        shared_out,
  output logic        supply,
  output logic        refresh,
  output logic        we,
  output line_state_e nxt
);
  always_comb begin
    shared_out = 1'b0;
    supply     = 1'b0;
    refresh    = 1'b0;
    we         = 1'b0;
    nxt        = cur;
    if (snp_valid && cur != LS_INV) begin
      unique case (snp_op)
        BO_READ: begin
          shared_out = 1'b1;
          supply     = (cur == LS_DIRT);
          we         = 1'b1;
          nxt        = LS_SHR;
        end
        BO_UPD: begin
          shared_out = 1'b1;
          refresh    = 1'b1;
          we         = 1'b1;
          nxt        = LS_SHR;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wu_bcast_cnt.sv
module wu_bcast_cnt #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             inc,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (inc[g] && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end
  end
endmodule

// File: rtl/wu_snoop_ctrl.sv
module wu_snoop_ctrl
  import wu_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_valid,
  input  logic [1:0]       proc_op,
  input  logic [IDX_W-1:0] proc_idx,
  output logic             proc_ack,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             shared_in,
  output logic             shared_out,
  output logic             supply_data,
  output logic             refresh,
  output logic             bus_req_valid,
  output logic [1:0]       bus_req_op,
  output logic [IDX_W-1:0] bus_req_idx,
  input  logic [IDX_W-1:0] lookup_idx,
  output logic [1:0]       lookup_state,
  output logic [CNT_W-1:0] cnt_rd,
  output logic [CNT_W-1:0] cnt_upd,
  output logic [CNT_W-1:0] cnt_wb
);
  localparam int CH_RD  = 0;
  localparam int CH_UPD = 1;
  localparam int CH_WB  = 2;
  localparam int NUM_CH = 3;

  line_state_e st_q [NUM_LINES];

  // Named internal events, visible to the bound checker
  line_state_e proc_cur, snp_cur, proc_nxt, snp_nxt;
  logic        proc_we, snp_we;
  bus_op_e     issue_op;
  logic        ev_rd, ev_upd, ev_wb;

  assign proc_cur = st_q[proc_idx];
  assign snp_cur  = st_q[snp_idx];

  wu_proc_fsm u_proc (
    .proc_valid (proc_valid),
    .proc_op    (proc_op),
    .cur        (proc_cur),
    .shared_in  (shared_in),
    .blocked    (snp_valid),
    .ack        (proc_ack),
    .bus_valid  (bus_req_valid),
    .bus_op     (issue_op),
    .we         (proc_we),
    .nxt        (proc_nxt)
  );

  wu_snoop_resp u_snp (
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .cur        (snp_cur),
    .shared_out (shared_out),
    .supply     (supply_data),
    .refresh    (refresh),
    .we         (snp_we),
    .nxt        (snp_nxt)
  );

  assign bus_req_op   = issue_op;
  assign bus_req_idx  = proc_idx;
  assign lookup_state = st_q[lookup_idx];

  // Processor updates are suppressed whenever a snoop is present,
  // so the two write enables never act in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_INV;
    end else if (snp_we) begin
      st_q[snp_idx] <= snp_nxt;
    end else if (proc_we) begin
      st_q[proc_idx] <= proc_nxt;
    end
  end

  assign ev_rd  = bus_req_valid && issue_op == BO_READ;
  assign ev_upd = bus_req_valid && issue_op == BO_UPD;
  assign ev_wb  = (bus_req_valid && issue_op == BO_WB) || supply_data;

  logic [NUM_CH-1:0]            cnt_inc;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;

  assign cnt_inc[CH_RD]  = ev_rd;
  assign cnt_inc[CH_UPD] = ev_upd;
  assign cnt_inc[CH_WB]  = ev_wb;

  wu_bcast_cnt #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cnt_inc),
    .cnt   (cnt_all)
  );

  assign cnt_rd  = cnt_all[CH_RD];
  assign cnt_upd = cnt_all[CH_UPD];
  assign cnt_wb  = cnt_all[CH_WB];
endmodule

// File: rtl/wu_snoop_chk.sv
module wu_snoop_chk
  import wu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             proc_valid,
  input logic [1:0]       proc_op,
  input line_state_e      proc_cur,
  input logic             proc_ack,
  input logic             snp_valid,
  input logic             shared_out,
  input logic             supply_data,
  input logic             refresh,
  input logic             bus_req_valid,
  input logic [1:0]       bus_req_op,
  input logic [CNT_W-1:0] cnt_rd,
  input logic [CNT_W-1:0] cnt_upd
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_SNOOP_HOLDS_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!proc_ack && !bus_req_valid)); // R10

  AST_SUPPLY_WITH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    supply_data |-> shared_out); // R8

  AST_REFRESH_WITH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> (shared_out && !supply_data)); // R9

  AST_NO_SNOOP_NO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> (!shared_out && !supply_data && !refresh)); // R9

  AST_EXCL_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_valid && !snp_valid && proc_op == 2'd1 &&
     (proc_cur == LS_EXCL || proc_cur == LS_DIRT)) |-> (!bus_req_valid && proc_ack)); // R4

  AST_MISS_ISSUES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_valid && !snp_valid && proc_op == 2'd0 && proc_cur == LS_INV)
      |-> (bus_req_valid && bus_req_op == 2'd1)); // R2

  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_valid && !snp_valid && proc_op == 2'd0 && proc_cur != LS_INV)
      |-> !bus_req_valid); // R3

  AST_RD_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd == $past(cnt_rd)) || (cnt_rd == $past(cnt_rd) + 1'b1)); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_upd) == CMAX) |-> (cnt_upd == CMAX)); // R11
endmodule

bind wu_snoop_ctrl wu_snoop_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .proc_valid    (proc_valid),
  .proc_op       (proc_op),
  .proc_cur      (proc_cur),
  .proc_ack      (proc_ack),
  .snp_valid     (snp_valid),
  .shared_out    (shared_out),
  .supply_data   (supply_data),
  .refresh       (refresh),
  .bus_req_valid (bus_req_valid),
  .bus_req_op    (bus_req_op),
  .cnt_rd        (cnt_rd),
  .cnt_upd       (cnt_upd)
);

// File: tb/tb_wu_snoop_ctrl.sv
`timescale 1ns/100ps
module tb_wu_snoop_ctrl;
  localparam int NL = 4;
  localparam int CW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          proc_valid, snp_valid, shared_in;
  logic [1:0]    proc_op, snp_op;
  logic [IW-1:0] proc_idx, snp_idx, lookup_idx;
  logic          proc_ack, shared_out, supply_data, refresh, bus_req_valid;
  logic [1:0]    bus_req_op, lookup_state;
  logic [IW-1:0] bus_req_idx;
  logic [CW-1:0] cnt_rd, cnt_upd, cnt_wb;

  wu_snoop_ctrl #(.NUM_LINES(NL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .proc_valid(proc_valid), .proc_op(proc_op), .proc_idx(proc_idx), .proc_ack(proc_ack),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
    .shared_in(shared_in), .shared_out(shared_out),
    .supply_data(supply_data), .refresh(refresh),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_idx(bus_req_idx),
    .lookup_idx(lookup_idx), .lookup_state(lookup_state),
    .cnt_rd(cnt_rd), .cnt_upd(cnt_upd), .cnt_wb(cnt_wb)
  );

  typedef struct packed {
    logic       pv;   logic [1:0] pop; logic [1:0] pidx;
    logic       sv;   logic [1:0] sop; logic [1:0] sidx;
    logic       sh;
    logic [1:0] ebus; logic eack; logic eshr; logic esup; logic eref;
    logic [1:0] est;  logic [1:0] lidx;
  } vec_t;

  // pv pop pidx | sv sop sidx | sh | ebus eack eshr esup eref | est lidx
  localparam vec_t VEC [0:17] = '{
    '{1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0, 1'b0, 2'd1,1'b1,1'b0,1'b0,1'b0, 2'd1,2'd0}, // R2 miss, alone -> excl
    '{1'b1,2'd0,2'd0, 1'b0,2'd0,2'd0, 1'b0, 2'd0,1'b1,1'b0,1'b0,1'b0, 2'd1,2'd0}, // R3 hit
    '{1'b1,2'd1,2'd0, 1'b0,2'd0,2'd0, 1'b0, 2'd0,1'b1,1'b0,1'b0,1'b0, 2'd3,2'd0}, // R4 excl->dirty
    '{1'b1,2'd1,2'd0, 1'b0,2'd0,2'd0, 1'b1, 2'd0,1'b1,1'b0,1'b0,1'b0, 2'd3,2'd0}, // R4 dirty stays
    '{1'b0,2'd0,2'd0, 1'b1,2'd1,2'd0, 1'b0, 2'd0,1'b0,1'b1,1'b1,1'b0, 2'd2,2'd0}, // R8 dirty supplies
    '{1'b1,2'd1,2'd0, 1'b0,2'd0,2'd0, 1'b1, 2'd2,1'b1,1'b0,1'b0,1'b0, 2'd2,2'd0}, // R5 update, sharers
    '{1'b1,2'd1,2'd0, 1'b0,2'd0,2'd0, 1'b0, 2'd2,1'b1,1'b0,1'b0,1'b0, 2'd1,2'd0}, // R5 update, alone
    '{1'b1,2'd0,2'd1, 1'b0,2'd0,2'd0, 1'b1, 2'd1,1'b1,1'b0,1'b0,1'b0, 2'd2,2'd1}, // R2 miss -> shared
    '{1'b0,2'd0,2'd0, 1'b1,2'd2,2'd1, 1'b0, 2'd0,1'b0,1'b1,1'b0,1'b1, 2'd2,2'd1}, // R9 refresh
    '{1'b0,2'd0,2'd0, 1'b1,2'd2,2'd2, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd2}, // R9 invalid ignores
    '{1'b1,2'd1,2'd2, 1'b0,2'd0,2'd0, 1'b0, 2'd1,1'b1,1'b0,1'b0,1'b0, 2'd3,2'd2}, // R6 write miss alone
    '{1'b1,2'd2,2'd2, 1'b0,2'd0,2'd0, 1'b0, 2'd3,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd2}, // R7 dirty evict
    '{1'b1,2'd1,2'd3, 1'b0,2'd0,2'd0, 1'b1, 2'd1,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd3}, // R6 write miss shared
    '{1'b1,2'd1,2'd3, 1'b0,2'd0,2'd0, 1'b1, 2'd2,1'b1,1'b0,1'b0,1'b0, 2'd2,2'd3}, // R6 retry updates
    '{1'b1,2'd2,2'd3, 1'b0,2'd0,2'd0, 1'b0, 2'd0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd3}, // R7 shared evict
    '{1'b0,2'd0,2'd0, 1'b1,2'd1,2'd0, 1'b0, 2'd0,1'b0,1'b1,1'b0,1'b0, 2'd2,2'd0}, // R8 excl no supply
    '{1'b1,2'd1,2'd1, 1'b1,2'd1,2'd0, 1'b0, 2'd0,1'b0,1'b1,1'b0,1'b0, 2'd2,2'd1}, // R10 snoop wins
    '{1'b0,2'd0,2'd0, 1'b1,2'd3,2'd1, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd1}  // R9 snooped wb ignored
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic pv, input logic [1:0] pop, input logic [1:0] pidx,
                       input logic sv, input logic [1:0] sop, input logic [1:0] sidx,
                       input logic sh, input logic [1:0] lidx);
    @(negedge clk);
    proc_valid = pv; proc_op = pop; proc_idx = pidx;
    snp_valid = sv;  snp_op = sop;  snp_idx = sidx;
    shared_in = sh;  lookup_idx = lidx;
  endtask

  task automatic idle();
    @(negedge clk);
    proc_valid = 1'b0; snp_valid = 1'b0; shared_in = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int exp_rd = 0, exp_upd = 0, exp_wb = 0;
    proc_valid = 1'b0; proc_op = '0; proc_idx = '0;
    snp_valid = 1'b0;  snp_op = '0;  snp_idx = '0;
    shared_in = 1'b0;  lookup_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < NL; i++) begin
      @(negedge clk); lookup_idx = IW'(i); #1;
      check("R1 line state", lookup_state, 0);
    end
    check("R1 cnt_rd", cnt_rd, 0);
    check("R1 cnt_upd", cnt_upd, 0);
    check("R1 cnt_wb", cnt_wb, 0);

    // table-driven main function
    for (int v = 0; v < 18; v++) begin
      vec_t t;
      t = VEC[v];
      drive(t.pv, t.pop, t.pidx, t.sv, t.sop, t.sidx, t.sh, t.lidx);
      #1;
      check($sformatf("vec%0d R2-path bus op", v), bus_req_valid ? bus_req_op : 0, t.ebus);
      check($sformatf("vec%0d R10 proc_ack", v), proc_ack, t.eack);
      check($sformatf("vec%0d R8 shared_out", v), shared_out, t.eshr);
      check($sformatf("vec%0d R8 supply", v), supply_data, t.esup);
      check($sformatf("vec%0d R9 refresh", v), refresh, t.eref);
      if (bus_req_valid) check($sformatf("vec%0d R2 bus idx", v), bus_req_idx, t.pidx);
      if (t.ebus == 2'd1) exp_rd++;
      if (t.ebus == 2'd2) exp_upd++;
      if (t.ebus == 2'd3 || t.esup) exp_wb++;
      @(posedge clk); #1;
      check($sformatf("vec%0d R5 state after", v), lookup_state, t.est);
    end
    idle();
    #1;
    check("R11 cnt_rd", cnt_rd, exp_rd);
    check("R11 cnt_upd", cnt_upd, exp_upd);
    check("R11 cnt_wb", cnt_wb, exp_wb);

    // R11 saturation of the read counter
    for (int k = 0; k < 14; k++) begin
      drive(1'b1, 2'd2, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0);
      drive(1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0);
    end
    idle();
    #1;
    check("R11 cnt_rd saturates", cnt_rd, 15);
    check("R11 cnt_upd unchanged", cnt_upd, exp_upd);
    check("R2 line 0 exclusive after refill", lookup_state, 1);

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 line 0 after reset", lookup_state, 0);
    check("R1 cnt_rd after reset", cnt_rd, 0);
    check("R1 cnt_wb after reset", cnt_wb, 0);
    lookup_idx = 2'd1; #1;
    check("R1 line 1 after reset", lookup_state, 0);

    done = 1'b1;
    summary();
  end
endmodule